// File: doc/BRIEF.md
# Byte-Lane Bank Select Decoder

This block turns processor bus control signals into the per-bank controls of a memory built from byte-wide banks. The data width is a parameter of 16, 32 or 64 bits, giving two, four or eight byte lanes. Its inputs are the active-low byte enables, a memory/IO select, a write/read direction, an active-low read strobe and the address. It drives one active-low write strobe per lane, a set of active-high bank selects, a shared active-low output enable, an active-low chip select for a fixed window at the top of the address space, and the word address seen by the banks.

A write strobe needs two things: a memory write cycle and that lane's byte enable. On a read, every lane in the window is selected and the processor keeps only the bytes it wants. The lane-select address bits are dropped from the bank address, so processor address bit LANE_BITS drives bank address bit 0. The decode is combinational. An optional output register gives one cycle of latency for timing closure.

Top module: `bank_lane_decoder`

## Requirements
- R1: DATA_W may be 16, 32 or 64, giving LANES = DATA_W/8 byte lanes and LANE_BITS = log2(LANES). Any other value stops elaboration.
- R2: With DATA_W=16, be_n[1] enables the high bank, which holds odd bytes on data bits 15..8. be_n[0] enables the low bank, which holds even bytes on bits 7..0. On a memory write, be_n=00 drives both strobes low, 01 drives only wr_n[1] low, 10 drives only wr_n[0] low, and 11 drives neither.
- R3: bank_addr equals addr[ADDR_W-1:LANE_BITS]. The lane bits never reach the banks.
- R4: A memory write is recognised only when mem_io=1 (memory) and wr_rd=1 (write).
- R5: wr_n[i] is 0 exactly when be_n[i]=0 and the cycle is a memory write. It is 1 otherwise.
- R6: bank_sel[i] is 1 when cs_n=0 and the cycle is a memory write with be_n[i]=0. It is also 1 when cs_n=0 and rd_n=0; a read selects all lanes whatever the byte enables are.
- R7: cs_n is 0 exactly when mem_io=1 and addr bits ADDR_W-1 down to REGION_LSB are all 1. With the defaults this is 32'hFFF80000 to 32'hFFFFFFFF.
- R8: oe_n is 0 exactly when rd_n=0 and cs_n=0.
- R9: With REG_OUT=1, all outputs show the decode of the inputs at the previous rising clk edge. While rst_n=0 they are inactive: wr_n all ones, oe_n=1, cs_n=1, bank_sel zero and bank_addr zero.
- R10: An IO cycle (mem_io=0) asserts no write strobe, no bank select, no chip select and no output enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low reset of the output register |
| be_n | input | LANES | Active-low byte enables, one per lane |
| mem_io | input | 1 | 1 = memory cycle, 0 = IO cycle |
| wr_rd | input | 1 | 1 = write, 0 = read |
| rd_n | input | 1 | Active-low read strobe |
| addr | input | ADDR_W | Processor byte address |
| wr_n | output | LANES | Active-low write strobe per bank |
| oe_n | output | 1 | Shared active-low output enable |
| cs_n | output | 1 | Active-low chip select for the top window |
| bank_sel | output | LANES | Active-high select per bank |
| bank_addr | output | ADDR_W-LANE_BITS | Word address driven to the banks |

## Verification
A write qualifier and an active read strobe can be present in the same cycle. When they are, the write strobes and the output enable are both asserted, and each bank select is the OR of its write term and the all-lane read term. Random stimulus draws wr_rd and rd_n independently, so this overlap occurs often, inside and outside the window. Each output is compared separately with a bench model that builds the write path and the read path on their own and merges them only for bank_sel.

// File: rtl/bls_pkg.sv
package bls_pkg;
   function automatic bit width_ok(int w);
      return (w == 16) || (w == 32) || (w == 64);
   endfunction

   function automatic int lanes_of(int w);
      return w / 8;
   endfunction
endpackage

// File: rtl/bls_region.sv
module bls_region #(
   parameter int HI_W = 13
) (
   input  logic [HI_W-1:0] hi_bits,
   input  logic            mem_io,
   output logic            hit
);
   logic [HI_W-1:0] acc;
   // a chain of AND terms; one per compared address bit
   for (genvar k = 0; k < HI_W; k++) begin : g_and
      if (k == 0) begin : g_first
         assign acc[k] = hi_bits[k];
      end else begin : g_next
         assign acc[k] = acc[k-1] & hi_bits[k];
      end
   end
   assign hit = mem_io & acc[HI_W-1];
endmodule

// File: rtl/bls_qualify.sv
module bls_qualify (
   input  logic mem_io,
   input  logic wr_rd,
   input  logic rd_n,
   input  logic hit,
   output logic mem_wr,
   output logic rd_en
);
   assign mem_wr = mem_io & wr_rd;
   assign rd_en  = ~rd_n & hit;
endmodule

// File: rtl/bls_lanes.sv
module bls_lanes #(
   parameter int LANES = 8
) (
   input  logic [LANES-1:0] be_n,
   input  logic             mem_wr,
   input  logic             rd_en,
   input  logic             hit,
   output logic [LANES-1:0] wr_n,
   output logic [LANES-1:0] sel
);
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic lane_wr;
      assign lane_wr = mem_wr & ~be_n[i];
      assign wr_n[i] = ~lane_wr;
      assign sel[i]  = (hit & lane_wr) | rd_en;
   end
endmodule

// File: rtl/bls_outreg.sv
module bls_outreg #(
   parameter int W       = 8,
   parameter bit REG_OUT = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] rst_val,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] q_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_r <= rst_val;
      else        q_r <= d;
   end

   if (REG_OUT) begin : g_reg
      assign q = q_r;
   end else begin : g_comb
      assign q = d;
   end
endmodule

// File: rtl/bank_lane_decoder.sv
module bank_lane_decoder
   import bls_pkg::*;
#(
   parameter int DATA_W     = 64,
   parameter int ADDR_W     = 32,
   parameter int REGION_LSB = 19,
   parameter bit REG_OUT    = 1'b0,
   localparam int LANES     = DATA_W / 8,
   localparam int LANE_BITS = $clog2(LANES),
   localparam int BA_W      = ADDR_W - LANE_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LANES-1:0]  be_n,
   input  logic              mem_io,
   input  logic              wr_rd,
   input  logic              rd_n,
   input  logic [ADDR_W-1:0] addr,
   output logic [LANES-1:0]  wr_n,
   output logic              oe_n,
   output logic              cs_n,
   output logic [LANES-1:0]  bank_sel,
   output logic [BA_W-1:0]   bank_addr
);
   localparam int HI_W  = ADDR_W - REGION_LSB;
   localparam int PACK_W = LANES + 2 + LANES + BA_W;

   if (!width_ok(DATA_W)) begin : g_bad_width
      $error("bank_lane_decoder: DATA_W must be 16, 32 or 64");
   end
   if (REGION_LSB <= LANE_BITS || REGION_LSB >= ADDR_W) begin : g_bad_region
      $error("bank_lane_decoder: REGION_LSB out of range");
   end

   logic             hit;
   logic             mem_wr;
   logic             rd_en;
   logic [LANES-1:0] wr_n_c;
   logic [LANES-1:0] sel_c;

   bls_region #(.HI_W(HI_W)) u_region (
      .hi_bits (addr[ADDR_W-1:REGION_LSB]),
      .mem_io  (mem_io),
      .hit     (hit)
   );

   bls_qualify u_qual (
      .mem_io (mem_io),
      .wr_rd  (wr_rd),
      .rd_n   (rd_n),
      .hit    (hit),
      .mem_wr (mem_wr),
      .rd_en  (rd_en)
   );

   bls_lanes #(.LANES(LANES)) u_lanes (
      .be_n   (be_n),
      .mem_wr (mem_wr),
      .rd_en  (rd_en),
      .hit    (hit),
      .wr_n   (wr_n_c),
      .sel    (sel_c)
   );

   logic [PACK_W-1:0] pack_d;
   logic [PACK_W-1:0] pack_q;
   logic [PACK_W-1:0] pack_rst;

   assign pack_d   = {wr_n_c, ~rd_en, ~hit, sel_c, addr[ADDR_W-1:LANE_BITS]};
   assign pack_rst = {{LANES{1'b1}}, 1'b1, 1'b1, {LANES{1'b0}}, {BA_W{1'b0}}};

   bls_outreg #(.W(PACK_W), .REG_OUT(REG_OUT)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .rst_val (pack_rst),
      .d       (pack_d),
      .q       (pack_q)
   );

   assign {wr_n, oe_n, cs_n, bank_sel, bank_addr} = pack_q;
endmodule

// File: rtl/bls_checker.sv
module bls_checker #(
   parameter int DATA_W     = 64,
   parameter int ADDR_W     = 32,
   parameter int REGION_LSB = 19,
   parameter bit REG_OUT    = 1'b0,
   localparam int LANES     = DATA_W / 8,
   localparam int HI_W      = ADDR_W - REGION_LSB
) (
   input logic             clk,
   input logic             rst_n,
   input logic [LANES-1:0] be_n,
   input logic             mem_io,
   input logic             wr_rd,
   input logic             rd_n,
   input logic [HI_W-1:0]  hi_bits,
   input logic [LANES-1:0] wr_n,
   input logic             oe_n,
   input logic             cs_n,
   input logic [LANES-1:0] bank_sel
);
   logic [LANES-1:0] d_be_n;
   logic             d_mem, d_wr;
   logic [HI_W-1:0]  d_hi;

   if (REG_OUT) begin : g_dly
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            d_be_n <= '1;
            d_mem  <= 1'b0;
            d_wr   <= 1'b0;
            d_hi   <= '0;
         end else begin
            d_be_n <= be_n;
            d_mem  <= mem_io;
            d_wr   <= wr_rd;
            d_hi   <= hi_bits;
         end
      end
   end else begin : g_now
      assign d_be_n = be_n;
      assign d_mem  = mem_io;
      assign d_wr   = wr_rd;
      assign d_hi   = hi_bits;
   end

   logic rd_unused;
   assign rd_unused = rd_n;

   AST_STROBE_NEEDS_MEMWR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_n != {LANES{1'b1}}) |-> (d_mem && d_wr)); // R4
   AST_STROBE_IN_ENABLED_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      (((~wr_n) & d_be_n) == '0)); // R5
   AST_READ_SELECTS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_n |-> (bank_sel == {LANES{1'b1}})); // R6
   AST_CS_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n |-> (d_mem && (&d_hi))); // R7
   AST_OE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_n |-> !cs_n); // R8
   AST_IO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !d_mem |-> (cs_n && oe_n && (bank_sel == '0))); // R10
endmodule

bind bank_lane_decoder bls_checker #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .REGION_LSB(REGION_LSB), .REG_OUT(REG_OUT)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .be_n     (be_n),
   .mem_io   (mem_io),
   .wr_rd    (wr_rd),
   .rd_n     (rd_n),
   .hi_bits  (addr[ADDR_W-1:REGION_LSB]),
   .wr_n     (wr_n),
   .oe_n     (oe_n),
   .cs_n     (cs_n),
   .bank_sel (bank_sel)
);

// File: tb/tb_bank_lane_decoder.sv
module tb_bank_lane_decoder;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   logic [7:0]  be_n = 8'hFF;
   logic        mem_io = 1'b0, wr_rd = 1'b0, rd_n = 1'b1;
   logic [31:0] addr = 32'h0;

   logic [7:0]  w64, s64;
   logic        oe64, cs64;
   logic [28:0] ba64;
   logic [1:0]  w16, s16;
   logic        oe16, cs16;
   logic [30:0] ba16;

   bank_lane_decoder #(.DATA_W(64), .ADDR_W(32), .REGION_LSB(19), .REG_OUT(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .be_n(be_n), .mem_io(mem_io), .wr_rd(wr_rd),
      .rd_n(rd_n), .addr(addr), .wr_n(w64), .oe_n(oe64), .cs_n(cs64),
      .bank_sel(s64), .bank_addr(ba64));

   bank_lane_decoder #(.DATA_W(16), .ADDR_W(32), .REGION_LSB(20), .REG_OUT(1'b1)) dut16 (
      .clk(clk), .rst_n(rst_n), .be_n(be_n[1:0]), .mem_io(mem_io), .wr_rd(wr_rd),
      .rd_n(rd_n), .addr(addr), .wr_n(w16), .oe_n(oe16), .cs_n(cs16),
      .bank_sel(s16), .bank_addr(ba16));

   typedef struct packed {
      logic [7:0]  wr_n;
      logic        oe_n;
      logic        cs_n;
      logic [7:0]  sel;
      logic [31:0] ba;
   } exp_t;

   function automatic exp_t model(int lanes, int lsb, logic [7:0] b, logic m,
                                  logic w, logic r, logic [31:0] a);
      exp_t e;
      logic hit, mw, re;
      hit = m && ((a >> lsb) == ((32'h1 << (32 - lsb)) - 32'h1));
      mw  = m && w;
      re  = !r && hit;
      e.wr_n = 8'hFF;
      e.sel  = 8'h00;
      for (int i = 0; i < lanes; i++) begin
         e.wr_n[i] = !(mw && !b[i]);
         e.sel[i]  = (hit && mw && !b[i]) || re;
      end
      e.oe_n = !re;
      e.cs_n = !hit;
      e.ba   = a >> $clog2(lanes);
      return e;
   endfunction

   task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
      end
   endtask

   task automatic chk64(string req, exp_t e);
      chk(req, "64 wr_n", {24'h0, w64}, {24'h0, e.wr_n});
      chk(req, "64 sel", {24'h0, s64}, {24'h0, e.sel});
      chk(req, "64 oe_n", {31'h0, oe64}, {31'h0, e.oe_n});
      chk(req, "64 cs_n", {31'h0, cs64}, {31'h0, e.cs_n});
      chk(req, "64 bank_addr", {3'h0, ba64}, e.ba);
   endtask

   task automatic chk16(string req, exp_t e);
      chk(req, "16 wr_n", {30'h0, w16}, {30'h0, e.wr_n[1:0]});
      chk(req, "16 sel", {30'h0, s16}, {30'h0, e.sel[1:0]});
      chk(req, "16 oe_n", {31'h0, oe16}, {31'h0, e.oe_n});
      chk(req, "16 cs_n", {31'h0, cs16}, {31'h0, e.cs_n});
      chk(req, "16 bank_addr", {1'b0, ba16}, e.ba);
   endtask

   exp_t prev16;

   // apply at negedge; comb result 1 ns later; registered result after next posedge
   task automatic step(string req, logic [7:0] b, logic m, logic w, logic r, logic [31:0] a);
      exp_t e64, e16;
      @(negedge clk);
      be_n = b; mem_io = m; wr_rd = w; rd_n = r; addr = a;
      e64 = model(8, 19, b, m, w, r, a);
      e16 = model(2, 20, b, m, w, r, a);
      #1;
      chk64(req, e64);
      chk16({req, " R9 hold"}, prev16);
      @(posedge clk);
      #1;
      chk16(req, e16);
      prev16 = e16;
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] a;
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      #1;
      // R9 reset state of the registered variant
      chk("R9", "reset wr_n", {30'h0, w16}, 32'h3);
      chk("R9", "reset oe_n", {31'h0, oe16}, 32'h1);
      chk("R9", "reset cs_n", {31'h0, cs16}, 32'h1);
      chk("R9", "reset sel", {30'h0, s16}, 32'h0);
      chk("R9", "reset bank_addr", {1'b0, ba16}, 32'h0);
      prev16 = model(2, 20, 8'hFF, 1'b0, 1'b0, 1'b1, 32'h0);
      prev16.ba = 32'h0;
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      prev16 = model(2, 20, 8'hFF, 1'b0, 1'b0, 1'b1, 32'h0);

      // R2 16-bit encoding table, memory write inside the window
      step("R2 both", 8'hFC, 1'b1, 1'b1, 1'b1, 32'hFFF0_1234);
      step("R2 high", 8'hFD, 1'b1, 1'b1, 1'b1, 32'hFFF0_1235);
      step("R2 low",  8'hFE, 1'b1, 1'b1, 1'b1, 32'hFFF0_1234);
      step("R2 none", 8'hFF, 1'b1, 1'b1, 1'b1, 32'hFFF0_1234);

      // R5 R4 every byte-enable pattern: memory write in window, then a read
      for (int k = 0; k < 256; k++) begin
         step("R5 write sweep", k[7:0], 1'b1, 1'b1, 1'b1, 32'hFFFF_FFF8);
         step("R6 read sweep", k[7:0], 1'b1, 1'b0, 1'b0, 32'hFFF8_0000);
      end
      // R10 IO cycles with write and read strobes
      step("R10 io write", 8'h00, 1'b0, 1'b1, 1'b0, 32'hFFFF_FFFF);
      step("R10 io read",  8'h00, 1'b0, 1'b0, 1'b0, 32'hFFF8_0000);
      // R7 window edges
      step("R7 below", 8'h00, 1'b1, 1'b0, 1'b0, 32'hFFF7_FFFF);
      step("R7 bottom", 8'h00, 1'b1, 1'b0, 1'b0, 32'hFFF8_0000);
      step("R8 no rd", 8'h00, 1'b1, 1'b0, 1'b1, 32'hFFFF_0000);
      // R3 lane bits dropped
      step("R3 addr", 8'hFF, 1'b0, 1'b0, 1'b1, 32'h1234_5677);

      // R1 R6 random mix, half inside the window
      for (int n = 0; n < 400; n++) begin
         a = $urandom;
         if ($urandom_range(1, 0) == 1) a[31:19] = '1;
         step("R1 R6 random", 8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), a);
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule